// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is one general-purpose I/O port of up to eight pins, reached over a simple register bus. Software sees three registers. The output-data register holds the drive level of each pin. The direction register chooses which pins are driven. The pin register returns the synchronized pad levels. Toward the pads the block gives, for each pin, an output value, an output enable and a pull-up enable, and it takes the raw pad input.

When a pin is an input, its output-data bit turns the pin's pull-up on or off. When the pin is an output, the same bit sets the level it drives. A single global input, shared with every other port on the chip, turns off all pull-ups. It does not change any stored bit.

A write to the pin register does not store anything. Each one in the written word inverts the matching output-data bit. Software can therefore flip any group of pins in one bus cycle without reading first. Reads are combinational and appear in the same cycle as the read strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output-data and direction registers are all zeros. pad_oe, pad_out and pad_pu are all zero.
- R2: A write to address 0 stores bus_wdata in the output-data register. A read of address 0 returns the stored value, whatever the pad levels are.
- R3: A write to address 1 stores bus_wdata in the direction register. A read of address 1 returns the stored value.
- R4: A write to address 2 inverts every output-data bit whose bus_wdata bit is 1. It leaves the other output-data bits unchanged and never changes the direction register.
- R5: A read of address 2 returns pad_in through a two-stage synchronizer. A pad change set up before clock edge k is first seen on the read after edge k+1.
- R6: For every pin, pad_out equals the pin's output-data bit and pad_oe equals its direction bit (1 = output).
- R7: For every pin, pad_pu is 1 exactly when the direction bit is 0, the output-data bit is 1 and pullup_disable is 0.
- R8: While pullup_disable is 1, every pad_pu bit is 0 and the stored registers are unchanged. When it returns to 0, the earlier pull-up state comes back.
- R9: Address 3 reads as zero, and writes to it change no register.
- R10: While bus_re is 0, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| pullup_disable | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Drive value per pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Pull-up enable per pin |

## Verification
The hardest behaviour to reach is the toggle write, for every mix of stored bits and mask bits. It has to be shown to flip exactly the masked bits and to leave the direction alone. The bench loads many known output-data values, then sweeps every possible mask over each one and reads the result back. The synchronizer lag is checked by changing pad_in and reading in the cycle after the first edge and again after the second edge. Pull-ups are swept over all direction words with both states of the global disable.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH = 8,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic             bus_re,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             pullup_disable,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_PIN  = AW'(2);
  localparam logic [AW-1:0] A_NONE = AW'(3);

  logic [WIDTH-1:0] data_q, dir_q, sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DATA:  data_q <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_PIN:   data_q <= data_q ^ bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        A_DATA:  bus_rdata = data_q;
        A_DIR:   bus_rdata = dir_q;
        A_PIN:   bus_rdata = sync2_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign pad_pu  = ~dir_q & data_q & {WIDTH{~pullup_disable}};

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DATA) |=> pad_out == $past(bus_wdata));

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PIN) |=> pad_out == ($past(pad_out) ^ $past(bus_wdata)));

  assert_dir_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PIN) |=> $stable(pad_oe));

  assert_no_pu_on_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  assert_pu_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_disable |-> pad_pu == '0);

  assert_unused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_NONE) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = 0;
  logic       bus_re = 0;
  logic [7:0] bus_rdata;
  logic       pullup_disable = 0;
  logic [7:0] pad_in = 0;
  logic [7:0] pad_out, pad_oe, pad_pu;

  int checks = 0, fails = 0;
  int cycles = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pullup_disable(pullup_disable), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    bus_re = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_pu;
    #12 rst_n = 1;
    @(negedge clk);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    rd(2'd0, v); chk("R1 data", v, 8'h00);
    rd(2'd1, v); chk("R1 dir", v, 8'h00);

    // R2, R6: every data value, with pads driven to the complement
    for (int i = 0; i < 256; i++) begin
      pad_in = ~8'(i);
      wr(2'd0, 8'(i));
      rd(2'd0, v); chk("R2 data readback", v, 8'(i));
      chk("R6 pad_out", pad_out, 8'(i));
    end
    // R3, R6
    for (int i = 0; i < 256; i++) begin
      wr(2'd1, 8'(i));
      rd(2'd1, v); chk("R3 dir readback", v, 8'(i));
      chk("R6 pad_oe", pad_oe, 8'(i));
    end

    // R4: toggle sweep
    wr(2'd1, 8'h5A);
    for (int b = 0; b < 256; b += 17) begin
      for (int m = 0; m < 256; m++) begin
        wr(2'd0, 8'(b));
        wr(2'd2, 8'(m));
        rd(2'd0, v); chk("R4 toggle", v, 8'(b) ^ 8'(m));
      end
      rd(2'd1, v); chk("R4 dir untouched", v, 8'h5A);
    end

    // R7, R8: pull-up sweep
    foreach (v[k]) ;
    for (int d = 0; d < 256; d++) begin
      wr(2'd1, 8'(d));
      for (int pd = 0; pd < 2; pd++) begin
        logic [7:0] dv;
        dv = 8'(d * 37 + 11);
        pullup_disable = pd[0];
        wr(2'd0, dv);
        exp_pu = pd[0] ? 8'h00 : (~8'(d) & dv);
        chk(pd[0] ? "R8 pu forced off" : "R7 pull-up", pad_pu, exp_pu);
      end
    end
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'hFF);
    pullup_disable = 1;
    @(negedge clk);
    chk("R8 pu off", pad_pu, 8'h00);
    rd(2'd0, v); chk("R8 data kept", v, 8'hFF);
    rd(2'd1, v); chk("R8 dir kept", v, 8'h0F);
    pullup_disable = 0;
    #1 chk("R8 pu restored", pad_pu, 8'hF0);

    // R9
    wr(2'd3, 8'h77);
    rd(2'd0, v); chk("R9 data", v, 8'hFF);
    rd(2'd1, v); chk("R9 dir", v, 8'h0F);
    rd(2'd3, v); chk("R9 read zero", v, 8'h00);

    // R10
    bus_addr = 2'd0; bus_re = 0;
    #1 chk("R10 idle rdata", bus_rdata, 8'h00);

    // R5: synchronizer lag, several patterns
    for (int p = 0; p < 16; p++) begin
      logic [7:0] old_v, new_v;
      old_v = 8'(p * 13 + 3);
      new_v = 8'(p * 29 + 200);
      @(negedge clk); pad_in = old_v;
      @(negedge clk); @(negedge clk);
      @(negedge clk); pad_in = new_v;
      @(negedge clk);
      rd(2'd2, v); chk("R5 one edge", v, old_v);
      @(negedge clk);
      rd(2'd2, v); chk("R5 two edges", v, new_v);
      rd(2'd0, v); chk("R2 data not pads", v, 8'hFF);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule